// File: doc/BRIEF.md
# DMA Channel Command Controller

This block is the control side of one copy/XOR engine channel. It tracks whether the channel is idle, running or paused, and it accepts four commands: start, stop, pause and restart. Whether a command is legal depends on the state the channel is in. A command that is not legal for the current state changes nothing and raises a one-cycle flag. A stop issued while the channel is running does not abort at once. The channel enters a draining state, finishes the beat in progress, and goes back to idle on the engine's done pulse.

The block also holds the channel configuration and the next-descriptor pointer. The configuration is a register-access-protect bit, a source burst limit and a destination burst limit. A write to these control fields never alters the operation mode. The mode can only be changed through a separate mode-write path, and only while the channel is idle. Writing a descriptor pointer starts a transfer. The block refuses this with a busy flag when the channel is not idle, and with an alignment flag when the pointer is zero or misaligned for the current mode. The data mover and the descriptor fetch lie outside the block; the done input stands in for them.

States: IDLE, ACTIVE, PAUSED, DRAIN. Transitions:
- IDLE to ACTIVE on a start command or an accepted launch.
- ACTIVE to PAUSED on pause.
- ACTIVE to DRAIN on stop.
- ACTIVE to IDLE on done.
- PAUSED to ACTIVE on restart.
- DRAIN to IDLE on done.

Top module: `dma_chan_ctl`

## Requirements
- R1: After reset the status is idle (00), protect is 1, both burst limits are 4, the mode is DMA (0), the descriptor pointer is 0 and all flags are low.
- R2: The status output reads 00 for idle, 01 for running or draining, and 10 for paused; it never reads 11.
- R3: Command codes are start=1, stop=2, pause=3 and restart=4. Start is honoured only in idle, stop and pause only in active, and restart only in paused.
- R4: A stop in idle is a silent no-op: the state is unchanged and no flag is raised.
- R5: Every other command and state pair, including codes 0 and 5 to 7 and any command while draining, raises cmd_illegal_o for one cycle and leaves the state unchanged.
- R6: A stop in active enters draining: eng_run_o drops, eng_stop_o rises, the status stays 01, and a done pulse returns the channel to idle.
- R7: A done pulse in active returns the channel to idle. A done pulse in idle or paused has no effect.
- R8: A descriptor write in idle with a valid pointer latches the pointer and enters active. In any other state it raises busy_err_o and changes neither the state nor the pointer.
- R9: In idle, a pointer is rejected with align_err_o, leaving the state and pointer unchanged, when it is zero or when its low bits are not clear. The number of low bits that must be clear is 6 for XOR (mode 1), 5 for DMA (0) and CRC (2), and 3 for memory-init (4).
- R10: A mode write in idle with code 0, 1, 2 or 4 sets the mode. Any other code, or any mode write outside idle, raises mode_err_o and leaves the mode unchanged.
- R11: A configuration write sets protect from bit 3, the source burst from bits 6:4 and the destination burst from bits 9:7; bits 2:0 are ignored and the mode is unchanged.
- R12: eng_run_o is high exactly when the channel is active (not paused, idle or draining).
- R13: A done pulse that takes effect silently drops any command or launch in the same cycle. A command and a launch in the same cycle let the command act, and the launch raises busy_err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_code_i | input | 3 | Command code |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_word_i | input | 4+2*BW | Configuration word |
| mode_wr_i | input | 1 | Mode write strobe |
| mode_i | input | 3 | New operation mode |
| desc_wr_i | input | 1 | Descriptor write and launch strobe |
| desc_ptr_i | input | AW | Descriptor pointer |
| eng_done_i | input | 1 | Engine done pulse |
| status_o | output | 2 | Channel status |
| eng_run_o | output | 1 | Engine may move data |
| eng_stop_o | output | 1 | Engine asked to finish its beat |
| next_desc_o | output | AW | Latched descriptor pointer |
| op_mode_o | output | 3 | Operation mode |
| acc_prot_o | output | 1 | Register-access protect |
| src_burst_o | output | BW | Source burst limit |
| dst_burst_o | output | BW | Destination burst limit |
| cmd_illegal_o | output | 1 | Illegal command pulse |
| busy_err_o | output | 1 | Launch refused because the channel is busy |
| align_err_o | output | 1 | Launch refused because of a bad pointer |
| mode_err_o | output | 1 | Mode write refused |

## Verification
The hardest case to reach from the ports is the draining state. It exists only between a stop and the next done pulse, and its status reads the same as active. The bench builds it by resetting, launching a valid pointer, and issuing stop. It then sweeps all eight command codes against each of the four states, with a fresh setup before each code. It also drives collisions of done with a command, and of a command with a launch, in the same cycle.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_ACTIVE = 2'b01,
        ST_PAUSED = 2'b10,
        ST_DRAIN  = 2'b11
    } ch_state_e;

    localparam logic [2:0] CMD_START   = 3'd1;
    localparam logic [2:0] CMD_STOP    = 3'd2;
    localparam logic [2:0] CMD_PAUSE   = 3'd3;
    localparam logic [2:0] CMD_RESTART = 3'd4;

    localparam logic [2:0] MODE_DMA   = 3'd0;
    localparam logic [2:0] MODE_XOR   = 3'd1;
    localparam logic [2:0] MODE_CRC   = 3'd2;
    localparam logic [2:0] MODE_MINIT = 3'd4;

    function automatic logic mode_known(input logic [2:0] m);
        return (m == MODE_DMA) || (m == MODE_XOR) ||
               (m == MODE_CRC) || (m == MODE_MINIT);
    endfunction

    // number of low pointer bits that must be zero for a mode
    function automatic int unsigned align_bits(input logic [2:0] m);
        int unsigned n;
        unique case (m)
            MODE_XOR:   n = 6;
            MODE_MINIT: n = 3;
            default:    n = 5;
        endcase
        return n;
    endfunction

    function automatic logic [1:0] status_code(input ch_state_e s);
        return (s == ST_DRAIN) ? 2'b01 : s;
    endfunction

endpackage

// File: rtl/dma_chan_ptr_chk.sv
module dma_chan_ptr_chk
    import dma_chan_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [2:0]    mode_i,
    input  logic [AW-1:0] ptr_i,
    output logic          ok_o
);
    logic low_dirty;

    always_comb begin
        low_dirty = 1'b0;
        for (int i = 0; i < AW; i++) begin
            if ((i < int'(align_bits(mode_i))) && ptr_i[i]) begin
                low_dirty = 1'b1;
            end
        end
    end

    assign ok_o = (ptr_i != '0) && !low_dirty;

endmodule

// File: rtl/dma_chan_cfg.sv
module dma_chan_cfg
    import dma_chan_pkg::*;
#(
    parameter int BW        = 3,
    parameter int BURST_RST = 4,
    localparam int CW       = 4 + 2*BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr_i,
    input  logic [CW-1:0] cfg_word_i,
    input  logic          mode_wr_i,
    input  logic [2:0]    mode_i,
    input  logic          chan_idle_i,
    output logic [2:0]    mode_o,
    output logic          prot_o,
    output logic [BW-1:0] src_o,
    output logic [BW-1:0] dst_o,
    output logic          mode_err_o
);
    logic mode_ok;
    assign mode_ok = mode_known(mode_i) && chan_idle_i;

    // control fields: mode bits [2:0] of the word are never looked at
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prot_o <= 1'b1;
            src_o  <= BW'(BURST_RST);
            dst_o  <= BW'(BURST_RST);
        end else if (cfg_wr_i) begin
            prot_o <= cfg_word_i[3];
            src_o  <= cfg_word_i[4 +: BW];
            dst_o  <= cfg_word_i[4+BW +: BW];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_o     <= MODE_DMA;
            mode_err_o <= 1'b0;
        end else begin
            mode_err_o <= mode_wr_i && !mode_ok;
            if (mode_wr_i && mode_ok) begin
                mode_o <= mode_i;
            end
        end
    end

endmodule

// File: rtl/dma_chan_fsm.sv
module dma_chan_fsm
    import dma_chan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid_i,
    input  logic [2:0] cmd_code_i,
    input  logic       launch_i,
    input  logic       launch_ok_i,
    input  logic       done_i,
    output ch_state_e  state_o,
    output logic       take_o,
    output logic       illegal_o,
    output logic       busy_o,
    output logic       align_o
);
    ch_state_e state_q, state_d;
    logic ill_d, busy_d, align_d, done_eff;

    assign done_eff = done_i && (state_q == ST_ACTIVE || state_q == ST_DRAIN);

    always_comb begin
        state_d = state_q;
        ill_d   = 1'b0;
        busy_d  = 1'b0;
        align_d = 1'b0;
        take_o  = 1'b0;
        if (done_eff) begin
            state_d = ST_IDLE;
        end else if (cmd_valid_i) begin
            busy_d = launch_i;
            unique case (state_q)
                ST_IDLE: begin
                    if (cmd_code_i == CMD_START)     state_d = ST_ACTIVE;
                    else if (cmd_code_i != CMD_STOP) ill_d = 1'b1;
                end
                ST_ACTIVE: begin
                    if (cmd_code_i == CMD_STOP)       state_d = ST_DRAIN;
                    else if (cmd_code_i == CMD_PAUSE) state_d = ST_PAUSED;
                    else                              ill_d = 1'b1;
                end
                ST_PAUSED: begin
                    if (cmd_code_i == CMD_RESTART) state_d = ST_ACTIVE;
                    else                           ill_d = 1'b1;
                end
                ST_DRAIN: ill_d = 1'b1;
                default:  ill_d = 1'b1;
            endcase
        end else if (launch_i) begin
            if (state_q != ST_IDLE) begin
                busy_d = 1'b1;
            end else if (!launch_ok_i) begin
                align_d = 1'b1;
            end else begin
                take_o  = 1'b1;
                state_d = ST_ACTIVE;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            illegal_o <= 1'b0;
            busy_o    <= 1'b0;
            align_o   <= 1'b0;
        end else begin
            illegal_o <= ill_d;
            busy_o    <= busy_d;
            align_o   <= align_d;
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
    import dma_chan_pkg::*;
#(
    parameter int AW        = 32,
    parameter int BW        = 3,
    parameter int BURST_RST = 4,
    localparam int CW       = 4 + 2*BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid_i,
    input  logic [2:0]    cmd_code_i,
    input  logic          cfg_wr_i,
    input  logic [CW-1:0] cfg_word_i,
    input  logic          mode_wr_i,
    input  logic [2:0]    mode_i,
    input  logic          desc_wr_i,
    input  logic [AW-1:0] desc_ptr_i,
    input  logic          eng_done_i,
    output logic [1:0]    status_o,
    output logic          eng_run_o,
    output logic          eng_stop_o,
    output logic [AW-1:0] next_desc_o,
    output logic [2:0]    op_mode_o,
    output logic          acc_prot_o,
    output logic [BW-1:0] src_burst_o,
    output logic [BW-1:0] dst_burst_o,
    output logic          cmd_illegal_o,
    output logic          busy_err_o,
    output logic          align_err_o,
    output logic          mode_err_o
);
    ch_state_e st;
    logic      ptr_ok, take;

    dma_chan_ptr_chk #(.AW(AW)) u_ptr (
        .mode_i (op_mode_o),
        .ptr_i  (desc_ptr_i),
        .ok_o   (ptr_ok)
    );

    dma_chan_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid_i (cmd_valid_i),
        .cmd_code_i  (cmd_code_i),
        .launch_i    (desc_wr_i),
        .launch_ok_i (ptr_ok),
        .done_i      (eng_done_i),
        .state_o     (st),
        .take_o      (take),
        .illegal_o   (cmd_illegal_o),
        .busy_o      (busy_err_o),
        .align_o     (align_err_o)
    );

    dma_chan_cfg #(.BW(BW), .BURST_RST(BURST_RST)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_i    (cfg_wr_i),
        .cfg_word_i  (cfg_word_i),
        .mode_wr_i   (mode_wr_i),
        .mode_i      (mode_i),
        .chan_idle_i (st == ST_IDLE),
        .mode_o      (op_mode_o),
        .prot_o      (acc_prot_o),
        .src_o       (src_burst_o),
        .dst_o       (dst_burst_o),
        .mode_err_o  (mode_err_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    next_desc_o <= '0;
        else if (take) next_desc_o <= desc_ptr_i;
    end

    assign status_o   = status_code(st);
    assign eng_run_o  = (st == ST_ACTIVE);
    assign eng_stop_o = (st == ST_DRAIN);

endmodule

// File: rtl/dma_chan_ctl_chk.sv
module dma_chan_ctl_chk #(
    parameter int AW = 32,
    parameter int BW = 3,
    localparam int CW = 4 + 2*BW
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid_i,
    input logic [2:0]    cmd_code_i,
    input logic          mode_wr_i,
    input logic          eng_done_i,
    input logic [1:0]    status_o,
    input logic          eng_run_o,
    input logic          eng_stop_o,
    input logic [2:0]    op_mode_o,
    input logic          cmd_illegal_o,
    input logic          busy_err_o,
    input logic          align_err_o
);
    assert_status_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        status_o != 2'b11);

    assert_restart_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == 2'b01 && $past(status_o) == 2'b10) |->
            ($past(cmd_valid_i) && $past(cmd_code_i) == 3'd4));

    assert_illegal_no_move_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_illegal_o |-> ($stable(status_o) && $stable(eng_stop_o)));

    assert_drain_by_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_stop_o && !$past(eng_stop_o)) |->
            ($past(cmd_valid_i) && $past(cmd_code_i) == 3'd2));

    assert_busy_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_err_o |-> ($past(status_o) != 2'b00 || $past(cmd_valid_i)));

    assert_align_stays_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        align_err_o |-> (status_o == 2'b00 && $past(status_o) == 2'b00));

    assert_mode_guarded_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(op_mode_o) |-> ($past(mode_wr_i) && $past(status_o) == 2'b00));

    assert_run_vs_drain_R12: assert property (@(posedge clk) disable iff (!rst_n)
        eng_run_o |-> !eng_stop_o);

    assert_done_idles_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(eng_done_i) && $past(status_o) == 2'b01) |-> status_o == 2'b00);

endmodule

bind dma_chan_ctl dma_chan_ctl_chk #(.AW(AW), .BW(BW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid_i   (cmd_valid_i),
    .cmd_code_i    (cmd_code_i),
    .mode_wr_i     (mode_wr_i),
    .eng_done_i    (eng_done_i),
    .status_o      (status_o),
    .eng_run_o     (eng_run_o),
    .eng_stop_o    (eng_stop_o),
    .op_mode_o     (op_mode_o),
    .cmd_illegal_o (cmd_illegal_o),
    .busy_err_o    (busy_err_o),
    .align_err_o   (align_err_o)
);

// File: tb/dma_chan_ctl_tb.sv
module dma_chan_ctl_tb;
    localparam int AW = 32;
    localparam int BW = 3;
    localparam int CW = 4 + 2*BW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid_i = 1'b0;
    logic [2:0]    cmd_code_i = '0;
    logic          cfg_wr_i = 1'b0;
    logic [CW-1:0] cfg_word_i = '0;
    logic          mode_wr_i = 1'b0;
    logic [2:0]    mode_i = '0;
    logic          desc_wr_i = 1'b0;
    logic [AW-1:0] desc_ptr_i = '0;
    logic          eng_done_i = 1'b0;
    logic [1:0]    status_o;
    logic          eng_run_o, eng_stop_o;
    logic [AW-1:0] next_desc_o;
    logic [2:0]    op_mode_o;
    logic          acc_prot_o;
    logic [BW-1:0] src_burst_o, dst_burst_o;
    logic          cmd_illegal_o, busy_err_o, align_err_o, mode_err_o;

    int nvec = 0;
    int nfail = 0;

    always #4 clk = ~clk;

    dma_chan_ctl #(.AW(AW), .BW(BW)) u_dut (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        cmd_valid_i = 1'b0;
        cfg_wr_i    = 1'b0;
        mode_wr_i   = 1'b0;
        desc_wr_i   = 1'b0;
        eng_done_i  = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic cmd(input logic [2:0] c);
        cmd_valid_i = 1'b1;
        cmd_code_i  = c;
        tick();
    endtask

    task automatic launch(input logic [AW-1:0] p);
        desc_wr_i  = 1'b1;
        desc_ptr_i = p;
        tick();
    endtask

    // 0 idle, 1 active, 2 paused, 3 draining
    task automatic go_state(input int s);
        do_reset();
        if (s >= 1) launch(32'h100);
        if (s == 2) cmd(3'd3);
        if (s == 3) cmd(3'd2);
    endtask

    task automatic chk_state(input string req, input int s);
        chk(req, status_o, (s == 3) ? 2'b01 : s[1:0]);
        chk(req, eng_run_o, s == 1);
        chk(req, eng_stop_o, s == 3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        // R1 reset values
        do_reset();
        chk_state("R1", 0);
        chk("R1", acc_prot_o, 1);
        chk("R1", src_burst_o, 4);
        chk("R1", dst_burst_o, 4);
        chk("R1", op_mode_o, 0);
        chk("R1", next_desc_o, 0);
        chk("R1", {cmd_illegal_o, busy_err_o, align_err_o, mode_err_o}, 0);

        // R3 R4 R5 R6 R12 R2: all states x all codes
        for (int s = 0; s < 4; s++) begin
            for (int c = 0; c < 8; c++) begin
                int ns;
                logic ill;
                go_state(s);
                ns = s;
                ill = 1'b1;
                if (s == 0 && c == 1) begin ns = 1; ill = 0; end
                if (s == 0 && c == 2) begin ns = 0; ill = 0; end
                if (s == 1 && c == 2) begin ns = 3; ill = 0; end
                if (s == 1 && c == 3) begin ns = 2; ill = 0; end
                if (s == 2 && c == 4) begin ns = 1; ill = 0; end
                cmd(c[2:0]);
                chk_state("R3_R5_R12", ns);
                chk((s == 0 && c == 2) ? "R4" : "R5", cmd_illegal_o, ill);
            end
        end

        // R6 drain then done
        go_state(3);
        eng_done_i = 1'b1; tick();
        chk_state("R6", 0);

        // R7 done in active, idle, paused
        go_state(1);
        eng_done_i = 1'b1; tick();
        chk_state("R7", 0);
        eng_done_i = 1'b1; tick();
        chk_state("R7", 0);
        go_state(2);
        eng_done_i = 1'b1; tick();
        chk_state("R7", 2);

        // R10 mode sweep in idle
        do_reset();
        for (int m = 0; m < 8; m++) begin
            logic ok;
            logic [2:0] prev;
            prev = op_mode_o;
            ok = (m == 0 || m == 1 || m == 2 || m == 4);
            mode_wr_i = 1'b1; mode_i = m[2:0]; tick();
            chk("R10", mode_err_o, !ok);
            chk("R10", op_mode_o, ok ? m[2:0] : prev);
        end
        // R10 mode write outside idle refused
        go_state(1);
        mode_wr_i = 1'b1; mode_i = 3'd1; tick();
        chk("R10", mode_err_o, 1);
        chk("R10", op_mode_o, 0);

        // R9 R8 alignment sweep per mode
        for (int mi = 0; mi < 4; mi++) begin
            logic [2:0] m;
            int nb;
            m  = (mi == 3) ? 3'd4 : mi[2:0];
            nb = (m == 1) ? 6 : (m == 4) ? 3 : 5;
            for (int b = -1; b < 9; b++) begin
                logic [AW-1:0] p;
                logic ok;
                do_reset();
                mode_wr_i = 1'b1; mode_i = m; tick();
                p  = (b < 0) ? '0 : (AW'(1) << b);
                ok = (b >= nb);
                launch(p);
                chk("R9", align_err_o, !ok);
                chk_state("R9", ok ? 1 : 0);
                chk("R8", next_desc_o, ok ? p : '0);
            end
        end

        // R8 launch while busy
        for (int s = 1; s < 4; s++) begin
            go_state(s);
            launch(32'h2000);
            chk("R8", busy_err_o, 1);
            chk("R8", next_desc_o, 32'h100);
            chk_state("R8", s);
        end

        // R11 config write ignores mode bits
        do_reset();
        mode_wr_i = 1'b1; mode_i = 3'd2; tick();
        cfg_wr_i = 1'b1; cfg_word_i = {3'd6, 3'd1, 1'b0, 3'b111}; tick();
        chk("R11", acc_prot_o, 0);
        chk("R11", src_burst_o, 1);
        chk("R11", dst_burst_o, 6);
        chk("R11", op_mode_o, 2);

        // R13 done beats command
        go_state(1);
        eng_done_i = 1'b1; cmd_valid_i = 1'b1; cmd_code_i = 3'd3; tick();
        chk_state("R13", 0);
        chk("R13", cmd_illegal_o, 0);
        // R13 command beats launch
        do_reset();
        cmd_valid_i = 1'b1; cmd_code_i = 3'd1;
        desc_wr_i = 1'b1; desc_ptr_i = 32'h400; tick();
        chk_state("R13", 1);
        chk("R13", busy_err_o, 1);
        chk("R13", next_desc_o, 0);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule